// File: doc/BRIEF.md
# Programmable Interrupt Line Router

This block collects thirty-two level-sensitive interrupt requests from peripherals. It steers each request to one of a small set of output lines, or to none. The output lines drive fixed inputs of a parent interrupt controller. Because each output feeds a parent line of its own priority, choosing an output also sets how urgently a request is served. Software changes the steering at run time through a small register bank on a plain word-wide write/read bus.

A global enable register gates every input. A read-only snapshot register returns the raw level of all inputs, so a handler can find the peripheral behind a parent interrupt. Four steering words hold one 4-bit selector per input. Each output is the registered OR of every input that is high, enabled and steered to that output.

The bus uses a byte address. Bits [4:2] choose one 32-bit word. The register window is six words long. Reads are combinational from the address, and writes take effect at the clock edge on which `bus_wr` is high.

Top module: `irq_router`

## Requirements
- R1: A synchronous active-high reset clears the enable word and every selector. On the cycle after reset, all outputs read low, and the enable word and all four steering words read back as zero.
- R2: The word at byte offset 0x00 is the enable word. A write stores it, and a read returns it. Bit i set to 1 lets input i reach an output.
- R3: The word at offset 0x04 reads the present raw level of inputs 31..0, whatever the enable word holds. A write to it changes no register and no output.
- R4: The steering words sit at offsets 0x08, 0x0C, 0x10 and 0x14. The selector for input n is in word n/8 at bits 4*(n%8)+3 down to 4*(n%8). Each word reads back as written.
- R5: An input whose selector is 0 reaches no output, even when it is high and enabled.
- R6: A selector value k from 1 to NUM_OUT steers its input to output k-1. Output j is high when at least one input is high, enabled and has selector j+1.
- R7: An input whose enable bit is 0 reaches no output, whatever its selector.
- R8: Outputs are registered. A change on an input, or a configuration write, shows on the outputs after exactly one further rising clock edge past the edge that captures it.
- R9: Offsets 0x18 and 0x1C read as zero. Writes to them change no register.
- R10: Several inputs steered to the same output are ORed together. Inputs on different outputs do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | 5 | Byte address; bits [4:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr |
| irq_in | input | 32 | Level-sensitive peripheral requests |
| irq_out | output | NUM_OUT | Routed requests toward the parent controller |

## Verification
The hardest case to reach from the ports is one output that several enabled inputs drive at once. Meanwhile, other inputs on the same output are masked, and unrelated inputs sit on the highest output. The vector table builds this state one register write at a time, so each step changes a single selector or enable bit and the expected output word changes in a known way. Directed steps then check the one-edge latency, as distinct from combinational behaviour. They do this by sampling before and after the edge for both a request change and an enable write.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int NUM_IN        = 32;
    localparam int DATA_W        = 32;
    localparam int SEL_W         = 4;
    localparam int ADDR_W        = 5;
    localparam int SEL_PER_WORD  = DATA_W / SEL_W;
    localparam int NUM_RT_WORDS  = NUM_IN / SEL_PER_WORD;
    localparam int IDX_W         = 3;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [NUM_IN-1:0][SEL_W-1:0] sel_vec_t;

    typedef enum logic [IDX_W-1:0] {
        WD_ENABLE = 3'd0,
        WD_SNAP   = 3'd1,
        WD_STEER0 = 3'd2,
        WD_STEER1 = 3'd3,
        WD_STEER2 = 3'd4,
        WD_STEER3 = 3'd5
    } word_e;

    typedef struct packed {
        logic              wr;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [IDX_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:2];
    endfunction

    function automatic logic [IDX_W-1:0] steer_word(input int w);
        return IDX_W'(int'(WD_STEER0) + w);
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  bus_req_t            req,
    input  logic [NUM_IN-1:0]   irq_raw,
    output logic [NUM_IN-1:0]   enable_q,
    output sel_vec_t            sel_q,
    output logic [DATA_W-1:0]   rdata
);

    logic [NUM_RT_WORDS-1:0][DATA_W-1:0] steer_words;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            sel_q    <= '0;
        end else if (req.wr) begin
            if (req.idx == WD_ENABLE)
                enable_q <= req.wdata;
            for (int i = 0; i < NUM_IN; i++) begin
                if (req.idx == steer_word(i / SEL_PER_WORD))
                    sel_q[i] <= req.wdata[(i % SEL_PER_WORD)*SEL_W +: SEL_W];
            end
        end
    end

    genvar w, s;
    generate
        for (w = 0; w < NUM_RT_WORDS; w++) begin : g_word
            for (s = 0; s < SEL_PER_WORD; s++) begin : g_slot
                assign steer_words[w][s*SEL_W +: SEL_W] = sel_q[w*SEL_PER_WORD + s];
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (req.idx == WD_ENABLE)
            rdata = enable_q;
        else if (req.idx == WD_SNAP)
            rdata = irq_raw;
        for (int k = 0; k < NUM_RT_WORDS; k++) begin
            if (req.idx == steer_word(k))
                rdata = steer_words[k];
        end
    end

endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar
    import irq_route_pkg::*;
#(
    parameter int NUM_OUT = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_IN-1:0]   irq_raw,
    input  logic [NUM_IN-1:0]   enable_q,
    input  sel_vec_t            sel_q,
    output logic [NUM_OUT-1:0]  irq_out_q
);

    logic [NUM_IN-1:0]  live;
    logic [NUM_OUT-1:0] hit;

    assign live = irq_raw & enable_q;

    genvar j;
    generate
        for (j = 0; j < NUM_OUT; j++) begin : g_out
            logic [NUM_IN-1:0] match;
            always_comb begin
                for (int i = 0; i < NUM_IN; i++)
                    match[i] = (sel_q[i] == SEL_W'(j + 1));
            end
            assign hit[j] = |(live & match);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            irq_out_q <= '0;
        else
            irq_out_q <= hit;
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_route_pkg::*;
#(
    parameter int NUM_OUT = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [4:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [31:0]          irq_in,
    output logic [NUM_OUT-1:0]   irq_out
);

    bus_req_t            req;
    logic [NUM_IN-1:0]   mask_q;
    sel_vec_t            sel_q;

    assign req.wr    = bus_wr;
    assign req.idx   = word_of(bus_addr);
    assign req.wdata = bus_wdata;

    irq_route_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .irq_raw  (irq_in),
        .enable_q (mask_q),
        .sel_q    (sel_q),
        .rdata    (bus_rdata)
    );

    irq_route_xbar #(.NUM_OUT(NUM_OUT)) u_xbar (
        .clk       (clk),
        .rst       (rst),
        .irq_raw   (irq_in),
        .enable_q  (mask_q),
        .sel_q     (sel_q),
        .irq_out_q (irq_out)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NUM_OUT = 15
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [4:0]         bus_addr,
    input logic [31:0]        bus_rdata,
    input logic [31:0]        irq_in,
    input logic [NUM_OUT-1:0] irq_out,
    input logic [31:0]        mask_q
);

    // R1
    reset_clears_out_chk: assert property (@(posedge clk)
        rst |=> (irq_out == '0));

    // R3
    snap_reads_raw_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[4:2] == 3'd1) |-> (bus_rdata == irq_in));

    // R6
    idle_inputs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_in & mask_q) == '0) |=> (irq_out == '0));

    // R7
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |=> (irq_out == '0));

    // R8
    steady_out_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_wr) && $stable(irq_in)) |=> $stable(irq_out));

endmodule

bind irq_router irq_router_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .irq_out   (irq_out),
    .mask_q    (mask_q)
);

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;

    localparam int NOUT = 15;
    localparam int NV   = 11;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_wr = 1'b0;
    logic [4:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [31:0]     irq_in = '0;
    logic [NOUT-1:0] irq_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_router #(.NUM_OUT(NOUT)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    // {addr, wdata, irq_in, expected irq_out}
    localparam logic [83:0] VEC [NV] = '{
        {5'h00, 32'hFFFF_FFFF, 32'h0000_0001, 15'h0000},  // R5 selector 0
        {5'h08, 32'h0000_0001, 32'h0000_0001, 15'h0001},  // R6 in0 -> out0
        {5'h08, 32'h0000_0021, 32'h0000_0003, 15'h0003},  // R6 in1 -> out1
        {5'h14, 32'hF000_0000, 32'h8000_0000, 15'h4000},  // R6 in31 -> out14
        {5'h0C, 32'h0000_0001, 32'h0000_0101, 15'h0001},  // R10 in0,in8 share out0
        {5'h00, 32'hFFFF_FFFE, 32'h8000_0103, 15'h4003},  // R7 in0 masked, R10
        {5'h00, 32'h0000_0000, 32'hFFFF_FFFF, 15'h0000},  // R7 all masked
        {5'h04, 32'hFFFF_FFFF, 32'h8000_0000, 15'h0000},  // R3 snapshot write ignored
        {5'h18, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 15'h0000},  // R9 spare write ignored
        {5'h00, 32'h8000_0000, 32'h8000_0000, 15'h4000},  // R2 enable in31 only
        {5'h10, 32'h7000_0000, 32'h0080_0000, 15'h0000}   // R7 in23 routed but masked
    };

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_word(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_word(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(irq_out == '0, "R1 out after reset", 32'(irq_out), 0);
        rd_word(5'h00, rd); check(rd == 0, "R1 enable after reset", rd, 0);
        for (int w = 0; w < 4; w++) begin
            rd_word(5'(8 + 4*w), rd);
            check(rd == 0, "R1 steer after reset", rd, 0);
        end

        // table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            bus_wr = 1'b1;
            bus_addr = VEC[v][83:79];
            bus_wdata = VEC[v][78:47];
            irq_in = VEC[v][46:15];
            @(negedge clk);
            bus_wr = 1'b0;
            @(negedge clk);
            if (irq_out !== VEC[v][14:0]) begin
                $display("FAIL R5/R6/R7/R10 vector %0d actual=%h expected=%h",
                         v, irq_out, VEC[v][14:0]);
                n_bad++;
            end
            n_chk++;
        end

        // R2 and R4 readback of the state built above
        rd_word(5'h00, rd); check(rd == 32'h8000_0000, "R2 enable readback", rd, 32'h8000_0000);
        rd_word(5'h08, rd); check(rd == 32'h0000_0021, "R4 steer0 readback", rd, 32'h21);
        rd_word(5'h0C, rd); check(rd == 32'h0000_0001, "R4 steer1 readback", rd, 32'h1);
        rd_word(5'h10, rd); check(rd == 32'h7000_0000, "R4 steer2 readback", rd, 32'h7000_0000);
        rd_word(5'h14, rd); check(rd == 32'hF000_0000, "R4 steer3 readback", rd, 32'hF000_0000);

        // R3 snapshot ignores enable, and ignores writes
        irq_in = 32'h1234_5678;
        rd_word(5'h04, rd); check(rd == 32'h1234_5678, "R3 snapshot raw", rd, 32'h1234_5678);
        wr_word(5'h04, 32'h0);
        rd_word(5'h04, rd); check(rd == 32'h1234_5678, "R3 snapshot after write", rd, 32'h1234_5678);
        rd_word(5'h00, rd); check(rd == 32'h8000_0000, "R3 enable untouched", rd, 32'h8000_0000);

        // R9 spare words
        rd_word(5'h18, rd); check(rd == 0, "R9 spare 0x18 reads zero", rd, 0);
        rd_word(5'h1C, rd); check(rd == 0, "R9 spare 0x1C reads zero", rd, 0);
        wr_word(5'h1C, 32'hFFFF_FFFF);
        rd_word(5'h14, rd); check(rd == 32'hF000_0000, "R9 steer3 untouched", rd, 32'hF000_0000);

        // R8 latency for an input change
        irq_in = 32'h0;
        wr_word(5'h00, 32'h0000_0001);
        @(negedge clk); @(negedge clk);
        check(irq_out == '0, "R8 idle before edge", 32'(irq_out), 0);
        irq_in = 32'h0000_0001;
        #1 check(irq_out == '0, "R8 no combinational path", 32'(irq_out), 0);
        @(negedge clk);
        check(irq_out == 15'h0001, "R8 one edge later", 32'(irq_out), 1);

        // R8 latency for a configuration write
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h0;
        @(negedge clk);
        bus_wr = 1'b0;
        check(irq_out == 15'h0001, "R8 write edge keeps old", 32'(irq_out), 1);
        @(negedge clk);
        check(irq_out == '0, "R8 write visible next edge", 32'(irq_out), 0);

        // R1 mid-run reset
        wr_word(5'h00, 32'hFFFF_FFFF);
        @(negedge clk);
        check(irq_out == 15'h0001, "R1 precondition out high", 32'(irq_out), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(irq_out == '0, "R1 out cleared by reset", 32'(irq_out), 0);
        rd_word(5'h08, rd); check(rd == 0, "R1 steer0 cleared", rd, 0);
        rd_word(5'h00, rd); check(rd == 0, "R1 enable cleared", rd, 0);

        finish_run();
    end

endmodule